// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This block is a small 32-bit processor that finishes one instruction on every rising clock edge. Each cycle it fetches a word from its instruction array, splits it into fixed fields, reads two registers, runs the ALU, optionally touches its data array, writes back one register and moves the program counter on. The instruction and data arrays are separate, so a fetch and a data access can happen in the same cycle.

The instruction set covers five register-to-register operations (add, subtract, bitwise and, bitwise or, signed set-less-than), word load, word store, branch when two registers are equal, and an absolute jump inside the current 256 MiB region. Signed overflow of add and subtract is reported on a pin but never stops the program. A side port lets the bench fill both arrays while the core is held in reset, and lets it read any register and any data word at any time.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low) the program counter is 0 and every register reads 0.
- R2: A word with opcode (bits 31:26) 0x00 and bits 10:6 zero is a register operation on rs (bits 25:21) and rt (bits 20:16), written to rd (bits 15:11); bits 5:0 choose 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed set-less-than (result 1 or 0).
- R3: Register 0 always reads 0; any write aimed at it is dropped.
- R4: Opcode 0x23 loads the data word at rs + sign-extended bits 15:0 into rt; opcode 0x2B stores rt at that address and writes no register; the data array is never read and written in the same cycle.
- R5: A load or store whose byte address is not a multiple of 4, or lies at or above 4 × `MEM_WORDS`, is ignored: no data word and no register changes.
- R6: Opcode 0x04 compares rs and rt; when equal the next PC is PC + 4 + (sign-extended bits 15:0 × 4), otherwise PC + 4.
- R7: Opcode 0x02 sets the next PC to bits 31:28 of PC + 4, then bits 25:0 of the word, then two zero bits.
- R8: A register written by one instruction holds the new value for the instruction in the next cycle.
- R9: `ovf_o` is high while the current add or subtract overflows as a signed operation; the wrapped result is still written and execution continues.
- R10: Any other opcode, any other function code, a register operation with nonzero bits 10:6, or a fetch beyond the instruction array changes nothing but the PC, which advances by 4.
- R11: With `ld_we` high during reset, `ld_data` is written to word `ld_addr` of the instruction array (`ld_dmem` = 0) or data array (`ld_dmem` = 1); `peek_reg_data` and `peek_mem_data` show the addressed register and data word combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_we | input | 1 | Side-port write strobe |
| ld_dmem | input | 1 | Side-port target: 0 instruction array, 1 data array |
| ld_addr | input | $clog2(MEM_WORDS) | Side-port word index |
| ld_data | input | 32 | Side-port write word |
| peek_reg | input | 5 | Register index to observe |
| peek_reg_data | output | 32 | Value of the observed register |
| peek_mem | input | $clog2(MEM_WORDS) | Data-array word index to observe |
| peek_mem_data | output | 32 | Value of the observed data word |
| pc_o | output | 32 | Current program counter |
| ovf_o | output | 1 | Signed overflow of the current add or subtract |

## Verification
Every instruction's effect lands on the first rising edge after it is fetched: the PC of the following instruction, a register write and a data store are all visible one edge later, while `ovf_o` belongs to the instruction currently at `pc_o` and is valid in the same cycle. The bench therefore compares one expected PC and overflow bit per cycle at each falling edge after reset is released, starting with the value due after the first edge. Register and data-array contents are compared through the peek ports only after the program has reached its closing self-loop, when nothing can change any more.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

    typedef enum logic [5:0] {
        OPC_REG   = 6'h00,
        OPC_JUMP  = 6'h02,
        OPC_BEQ   = 6'h04,
        OPC_LOADW = 6'h23,
        OPC_STORW = 6'h2B
    } opcode_e;

    typedef enum logic [5:0] {
        FN_ADD = 6'h20,
        FN_SUB = 6'h22,
        FN_AND = 6'h24,
        FN_OR  = 6'h25,
        FN_SLT = 6'h2A
    } funct_e;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT
    } alu_op_e;

    typedef struct packed {
        logic    reg_we;
        logic    dst_is_rd;
        logic    opb_imm;
        logic    mem_re;
        logic    mem_we;
        logic    wb_from_mem;
        logic    branch;
        logic    jump;
        logic    ovf_en;
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_core_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [4:0] shamt,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_ADD;
        case (opcode)
            OPC_REG: begin
                if (shamt == 5'd0) begin
                    case (funct)
                        FN_ADD: begin ctrl.reg_we = 1'b1; ctrl.dst_is_rd = 1'b1; ctrl.ovf_en = 1'b1; ctrl.alu_op = ALU_ADD; end
                        FN_SUB: begin ctrl.reg_we = 1'b1; ctrl.dst_is_rd = 1'b1; ctrl.ovf_en = 1'b1; ctrl.alu_op = ALU_SUB; end
                        FN_AND: begin ctrl.reg_we = 1'b1; ctrl.dst_is_rd = 1'b1; ctrl.alu_op = ALU_AND; end
                        FN_OR:  begin ctrl.reg_we = 1'b1; ctrl.dst_is_rd = 1'b1; ctrl.alu_op = ALU_OR;  end
                        FN_SLT: begin ctrl.reg_we = 1'b1; ctrl.dst_is_rd = 1'b1; ctrl.alu_op = ALU_SLT; end
                        default: ;
                    endcase
                end
            end
            OPC_LOADW: begin
                ctrl.reg_we      = 1'b1;
                ctrl.opb_imm     = 1'b1;
                ctrl.mem_re      = 1'b1;
                ctrl.wb_from_mem = 1'b1;
            end
            OPC_STORW: begin
                ctrl.opb_imm = 1'b1;
                ctrl.mem_we  = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            OPC_JUMP: begin
                ctrl.jump = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_core_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero,
    output logic         ovf
);
    logic [W-1:0] sum;
    logic [W-1:0] diff;

    always_comb begin
        sum  = a + b;
        diff = a - b;
        y    = sum;
        ovf  = 1'b0;
        case (op)
            ALU_ADD: begin
                y   = sum;
                ovf = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
            end
            ALU_SUB: begin
                y   = diff;
                ovf = (a[W-1] != b[W-1]) && (diff[W-1] != a[W-1]);
            end
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = sum;
        endcase
        zero = (y == '0);
    end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int W = 32,
    parameter int N = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] pa,
    output logic [W-1:0]  pd
);
    logic [W-1:0] rf_q [N];
    logic [W-1:0] rf_d [N];

    always_comb begin
        rf_d = rf_q;
        if (we && (wa != '0)) begin
            rf_d[wa] = wd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                rf_q[i] <= '0;
            end
        end else begin
            rf_q <= rf_d;
        end
    end

    assign rd1 = rf_q[ra1];
    assign rd2 = rf_q[ra2];
    assign pd  = rf_q[pa];

    // R3: location zero never holds anything but zero
    p_zero_reg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rf_q[0] == '0);

    // R8: a write is readable on the next cycle
    p_write_visible_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (wa != '0)) |=> (rf_q[$past(wa)] == $past(wd)));
endmodule

// File: rtl/sc_dmem.sv
module sc_dmem #(
    parameter int W     = 32,
    parameter int WORDS = 64,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          re,
    input  logic          we,
    input  logic [AW-1:0] idx,
    input  logic [W-1:0]  wd,
    output logic [W-1:0]  rd,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_idx,
    input  logic [W-1:0]  ld_data,
    input  logic [AW-1:0] pk_idx,
    output logic [W-1:0]  pk_data
);
    logic [W-1:0] mem_q [WORDS];
    logic [W-1:0] mem_d [WORDS];

    always_comb begin
        mem_d = mem_q;
        if (ld_we) begin
            mem_d[ld_idx] = ld_data;
        end else if (we) begin
            mem_d[idx] = wd;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rd      = re ? mem_q[idx] : '0;
    assign pk_data = mem_q[pk_idx];
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_core_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int MEM_WORDS = 64,
    localparam int MAW      = $clog2(MEM_WORDS),
    localparam int NREG     = 32,
    localparam int RAW      = $clog2(NREG),
    localparam int IMMW     = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_we,
    input  logic            ld_dmem,
    input  logic [MAW-1:0]  ld_addr,
    input  logic [XLEN-1:0] ld_data,
    input  logic [RAW-1:0]  peek_reg,
    output logic [XLEN-1:0] peek_reg_data,
    input  logic [MAW-1:0]  peek_mem,
    output logic [XLEN-1:0] peek_mem_data,
    output logic [XLEN-1:0] pc_o,
    output logic            ovf_o
);
    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;

    core_state_t st_q, st_d;

    logic [XLEN-1:0] imem_q [MEM_WORDS];
    logic [XLEN-1:0] imem_d [MEM_WORDS];

    logic            fetch_ok;
    logic [XLEN-1:0] instr;
    ctrl_t           ctrl;
    logic [XLEN-1:0] rs_val, rt_val, opb, imm_sx;
    logic [XLEN-1:0] alu_y;
    logic            alu_zero, alu_ovf;
    logic            dm_ok, dm_re, dm_we;
    logic [XLEN-1:0] dm_rd, wb_data;
    logic            rf_we;
    logic [RAW-1:0]  rf_wa;
    logic [XLEN-1:0] pc4, br_tgt, jmp_tgt;

    // instruction array, written only through the side port
    always_comb begin
        imem_d = imem_q;
        if (ld_we && !ld_dmem) begin
            imem_d[ld_addr] = ld_data;
        end
    end

    always_ff @(posedge clk) begin
        imem_q <= imem_d;
    end

    assign fetch_ok = (st_q.pc[1:0] == 2'b00) && (st_q.pc[XLEN-1:MAW+2] == '0);
    assign instr    = fetch_ok ? imem_q[st_q.pc[MAW+1:2]] : '0;

    sc_decode u_decode (
        .opcode (instr[31:26]),
        .shamt  (instr[10:6]),
        .funct  (instr[5:0]),
        .ctrl   (ctrl)
    );

    assign rf_wa = ctrl.dst_is_rd ? instr[15:11] : instr[20:16];

    sc_regfile #(.W(XLEN), .N(NREG)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (instr[25:21]),
        .ra2   (instr[20:16]),
        .rd1   (rs_val),
        .rd2   (rt_val),
        .we    (rf_we),
        .wa    (rf_wa),
        .wd    (wb_data),
        .pa    (peek_reg),
        .pd    (peek_reg_data)
    );

    assign imm_sx = {{(XLEN-IMMW){instr[IMMW-1]}}, instr[IMMW-1:0]};
    assign opb    = ctrl.opb_imm ? imm_sx : rt_val;

    sc_alu #(.W(XLEN)) u_alu (
        .a    (rs_val),
        .b    (opb),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero),
        .ovf  (alu_ovf)
    );

    assign dm_ok = (alu_y[1:0] == 2'b00) && (alu_y[XLEN-1:MAW+2] == '0);
    assign dm_re = ctrl.mem_re && dm_ok;
    assign dm_we = ctrl.mem_we && dm_ok && rst_n;

    sc_dmem #(.W(XLEN), .WORDS(MEM_WORDS)) u_dmem (
        .clk     (clk),
        .re      (dm_re),
        .we      (dm_we),
        .idx     (alu_y[MAW+1:2]),
        .wd      (rt_val),
        .rd      (dm_rd),
        .ld_we   (ld_we && ld_dmem),
        .ld_idx  (ld_addr),
        .ld_data (ld_data),
        .pk_idx  (peek_mem),
        .pk_data (peek_mem_data)
    );

    assign wb_data = ctrl.wb_from_mem ? dm_rd : alu_y;
    assign rf_we   = ctrl.reg_we && (!ctrl.mem_re || dm_ok);

    // next program counter
    always_comb begin
        pc4     = st_q.pc + XLEN'(4);
        br_tgt  = pc4 + (imm_sx << 2);
        jmp_tgt = {pc4[XLEN-1:28], instr[25:0], 2'b00};
        st_d    = st_q;
        if (ctrl.jump) begin
            st_d.pc = jmp_tgt;
        end else if (ctrl.branch && alu_zero) begin
            st_d.pc = br_tgt;
        end else begin
            st_d.pc = pc4;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o  = st_q.pc;
    assign ovf_o = ctrl.ovf_en && alu_ovf;

    // R1: the first edge after reset release still sees PC zero
    p_reset_pc_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (st_q.pc == '0));

    // R4: data array never read and written together
    p_mem_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(dm_re && dm_we));

    // R4: a store leaves the register file alone
    p_store_no_wb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.mem_we |-> !rf_we);

    // R5: a misaligned access touches nothing
    p_misalign_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl.mem_re || ctrl.mem_we) && (alu_y[1:0] != 2'b00)) |-> (!dm_re && !dm_we && !rf_we));

    // R6: an unequal compare falls through
    p_beq_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.branch && (rs_val != rt_val)) |=> (st_q.pc == $past(st_q.pc) + XLEN'(4)));

    // R7: the jump field lands in PC bits 27:2
    p_jump_field_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.jump |=> (st_q.pc[27:2] == $past(instr[25:0])));

    // R10: an instruction with no effect only advances the PC
    p_nop_adv_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl.reg_we || ctrl.mem_we || ctrl.branch || ctrl.jump) |=> (st_q.pc == $past(st_q.pc) + XLEN'(4)));
endmodule

// File: tb/sc_core_tb.sv
`timescale 1ns/1ps
module sc_core_tb;
    localparam int KPC = 0, KPCNOW = 1, KREG = 2, KMEM = 3;

    typedef struct {
        int          kind;
        int          idx;
        logic [31:0] val;
        logic        ovf;
        string       req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_we = 1'b0;
    logic        ld_dmem = 1'b0;
    logic [5:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [4:0]  peek_reg = '0;
    logic [31:0] peek_reg_data;
    logic [5:0]  peek_mem = '0;
    logic [31:0] peek_mem_data;
    logic [31:0] pc_o;
    logic        ovf_o;

    item_t sb[$];
    int    pending = 0;
    int    checks  = 0;
    int    errors  = 0;
    bit    finished = 1'b0;

    always #10 clk = ~clk;

    sc_core u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ld_we         (ld_we),
        .ld_dmem       (ld_dmem),
        .ld_addr       (ld_addr),
        .ld_data       (ld_data),
        .peek_reg      (peek_reg),
        .peek_reg_data (peek_reg_data),
        .peek_mem      (peek_mem),
        .peek_mem_data (peek_mem_data),
        .pc_o          (pc_o),
        .ovf_o         (ovf_o)
    );

    function automatic logic [31:0] rop(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'h00, fn};
    endfunction

    function automatic logic [31:0] iop(logic [5:0] op, int rs, int rt, int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    task automatic report(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic push(int kind, int idx, logic [31:0] val, logic ovf, string req);
        item_t it;
        it.kind = kind; it.idx = idx; it.val = val; it.ovf = ovf; it.req = req;
        sb.push_back(it);
        pending++;
    endtask

    task automatic drain();
        while (pending != 0) @(clk);
    endtask

    task automatic load(bit to_dmem, int addr, logic [31:0] data);
        ld_dmem = to_dmem;
        ld_addr = 6'(addr);
        ld_data = data;
        ld_we   = 1'b1;
        @(negedge clk);
        ld_we   = 1'b0;
    endtask

    // monitor: pops expected items and compares as results appear
    initial begin
        item_t it;
        forever begin
            while (sb.size() == 0) @(clk);
            it = sb.pop_front();
            case (it.kind)
                KPC: begin
                    @(negedge clk);
                    report(pc_o == it.val, it.req, "pc", pc_o, it.val);
                    report(ovf_o == it.ovf, "R9", "ovf", {31'd0, ovf_o}, {31'd0, it.ovf});
                end
                KPCNOW: report(pc_o == it.val, it.req, "pc", pc_o, it.val);
                KREG: begin
                    peek_reg = 5'(it.idx);
                    #1;
                    report(peek_reg_data == it.val, it.req, $sformatf("reg %0d", it.idx), peek_reg_data, it.val);
                end
                default: begin
                    peek_mem = 6'(it.idx);
                    #1;
                    report(peek_mem_data == it.val, it.req, $sformatf("mem %0d", it.idx), peek_mem_data, it.val);
                end
            endcase
            pending--;
        end
    end

    // driver
    initial begin
        logic [31:0] prog [29];
        repeat (2) @(negedge clk);

        // R11: data words through the side port
        load(1'b1, 0, 32'd5);
        load(1'b1, 1, 32'd9);
        load(1'b1, 2, 32'd0);
        load(1'b1, 3, 32'h7FFF_FFFF);

        prog[0]  = iop(6'h23, 0, 1, 0);          // lw r1
        prog[1]  = iop(6'h23, 0, 2, 4);          // lw r2
        prog[2]  = rop(1, 2, 3, 6'h20);          // add
        prog[3]  = rop(1, 2, 4, 6'h22);          // sub
        prog[4]  = rop(1, 2, 5, 6'h24);          // and
        prog[5]  = rop(1, 2, 6, 6'h25);          // or
        prog[6]  = rop(1, 2, 7, 6'h2A);          // slt 5<9
        prog[7]  = rop(4, 1, 8, 6'h2A);          // slt -4<5
        prog[8]  = rop(1, 4, 14, 6'h2A);         // slt 5<-4
        prog[9]  = iop(6'h2B, 0, 3, 8);          // sw r3 -> word 2
        prog[10] = rop(1, 2, 0, 6'h20);          // write to r0
        prog[11] = iop(6'h23, 0, 9, 2);          // misaligned load
        prog[12] = iop(6'h2B, 0, 1, 6);          // misaligned store
        prog[13] = rop(1, 1, 10, 6'h20);         // r10 = 10
        prog[14] = rop(10, 10, 11, 6'h20);       // r11 = 20, uses r10 next cycle
        prog[15] = 32'hFC00_0000;                // undefined opcode
        prog[16] = iop(6'h23, 0, 12, 12);        // r12 = max positive
        prog[17] = rop(12, 12, 13, 6'h20);       // overflowing add
        prog[18] = iop(6'h04, 1, 1, 1);          // taken, skip one
        prog[19] = rop(1, 1, 15, 6'h20);         // skipped
        prog[20] = iop(6'h04, 1, 2, 3);          // not taken
        prog[21] = {6'h02, 26'd24};              // jump to word 24
        prog[22] = rop(1, 1, 16, 6'h20);         // skipped
        prog[23] = rop(1, 1, 16, 6'h20);         // skipped
        prog[24] = iop(6'h23, 11, 17, -8);       // negative offset load
        prog[25] = iop(6'h2B, 11, 6, -20);       // negative offset store to word 0
        prog[26] = iop(6'h23, 0, 18, 256);       // beyond the data array
        prog[27] = iop(6'h04, 0, 0, -1);         // self loop
        prog[28] = iop(6'h04, 0, 0, -1);
        for (int i = 0; i < 29; i++) load(1'b0, i, prog[i]);

        // R1: state while reset is held
        push(KPCNOW, 0, 32'd0, 1'b0, "R1");
        push(KREG, 5, 32'd0, 1'b0, "R1");
        push(KREG, 20, 32'd0, 1'b0, "R1");
        drain();

        @(negedge clk);
        rst_n = 1'b1;
        // R6 R7 R10: one expected PC per edge, R9 overflow on the word at 68
        for (int k = 1; k <= 18; k++) push(KPC, 0, 32'(4 * k), (4 * k) == 68, "R10");
        push(KPC, 0, 32'd80, 1'b0, "R6");
        push(KPC, 0, 32'd84, 1'b0, "R6");
        push(KPC, 0, 32'd96, 1'b0, "R7");
        push(KPC, 0, 32'd100, 1'b0, "R7");
        push(KPC, 0, 32'd104, 1'b0, "R4");
        push(KPC, 0, 32'd108, 1'b0, "R5");
        push(KPC, 0, 32'd108, 1'b0, "R6");
        push(KPC, 0, 32'd108, 1'b0, "R6");
        drain();

        push(KREG, 1, 32'd5, 1'b0, "R4");
        push(KREG, 2, 32'd9, 1'b0, "R4");
        push(KREG, 3, 32'd14, 1'b0, "R2");
        push(KREG, 4, 32'hFFFF_FFFC, 1'b0, "R2");
        push(KREG, 5, 32'd1, 1'b0, "R2");
        push(KREG, 6, 32'd13, 1'b0, "R2");
        push(KREG, 7, 32'd1, 1'b0, "R2");
        push(KREG, 8, 32'd1, 1'b0, "R2");
        push(KREG, 14, 32'd0, 1'b0, "R2");
        push(KREG, 0, 32'd0, 1'b0, "R3");
        push(KREG, 9, 32'd0, 1'b0, "R5");
        push(KREG, 10, 32'd10, 1'b0, "R8");
        push(KREG, 11, 32'd20, 1'b0, "R8");
        push(KREG, 12, 32'h7FFF_FFFF, 1'b0, "R4");
        push(KREG, 13, 32'hFFFF_FFFE, 1'b0, "R9");
        push(KREG, 15, 32'd0, 1'b0, "R6");
        push(KREG, 16, 32'd0, 1'b0, "R7");
        push(KREG, 17, 32'h7FFF_FFFF, 1'b0, "R4");
        push(KREG, 18, 32'd0, 1'b0, "R5");
        push(KMEM, 0, 32'd13, 1'b0, "R4");
        push(KMEM, 1, 32'd9, 1'b0, "R5");
        push(KMEM, 2, 32'd14, 1'b0, "R4");
        push(KMEM, 3, 32'h7FFF_FFFF, 1'b0, "R11");
        drain();

        // R1: reset again clears registers and PC
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        push(KPCNOW, 0, 32'd0, 1'b0, "R1");
        push(KREG, 3, 32'd0, 1'b0, "R1");
        push(KREG, 13, 32'd0, 1'b0, "R1");
        drain();

        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog all-requirements actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule